// File: doc/BRIEF.md
# Flash Command Upload Capture FIFO

This block sits inside a serial-peripheral device that behaves as a flash target. When the command decoder upstream announces that an uploaded command has been parsed, the block builds one 32-bit record holding the opcode and a frozen copy of three flash state flags. The flags are the busy flag, the write-enable latch and the wide-address mode. It then pushes the record into a command queue. A second queue of 32-bit words holds the addresses the decoder captures. Software-side reads pop records from either queue. A packed status word gives the fill level and a not-empty flag for each queue.

The block never raises an interrupt in the middle of a transaction. It only notes that an upload happened. When chip select is released in flash or passthrough mode, and the command queue holds data, and an upload arrived since the last release, it sets a sticky interrupt state bit. Software clears that bit with a write-one-to-clear strobe. A record that arrives when the queue is full is discarded, and the block gives a one-cycle error pulse. A pop from an empty queue returns zero and also gives a one-cycle error pulse.

Top module: `flash_cmd_capture`

## Requirements
- R1: A command record has the opcode in bits [7:0], the captured busy flag in bit 8, the write-enable latch in bit 9 and the wide-address mode in bit 10. Bits [31:11] are zero.
- R2: The busy bit of a record is 1 when the flash busy flag is set, and also when the uploaded command itself is marked to set busy. Each flag is sampled in the cycle of the upload.
- R3: The command queue holds 16 records and returns them in upload order. While `cmd_pop` is high and the queue is not empty, `cmd_rd_data` shows the oldest record, and that record is removed at the clock edge.
- R4: An upload while the command queue holds 16 records is dropped and the stored records are unchanged. `cmd_overflow` is high for exactly the one cycle that follows.
- R5: A pop from an empty command queue shows 0 on `cmd_rd_data` and leaves the depth at 0. `cmd_underflow` is high for exactly the one cycle that follows.
- R6: `upload_status` carries the command depth in [4:0], command not-empty in bit 7, the address depth in [12:8] and address not-empty in bit 15. All other bits are zero. It reflects the queues after each clock edge.
- R7: On a `csb_release` cycle with `flash_mode` high, `irq_cmd_ne` becomes 1 at that edge when the command queue is non-empty and an upload has occurred since the previous release. With `flash_mode` low, a release never sets it.
- R8: Every upload sets the pending-upload condition, including an upload that is dropped. Any `csb_release` clears it, so a second release with no new upload does not set the interrupt.
- R9: `irq_cmd_ne` stays set until an `irq_clr` cycle clears it. A set and a clear in the same cycle leave it set.
- R10: A synchronous active-low reset empties both queues, clears the interrupt and the pending-upload condition, and leaves all outputs at 0.
- R11: The address queue holds 16 words in order. A push while it is full is dropped, `addr_overflow` pulses for one cycle and the stored words are kept. A pop from an empty address queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flash_mode | input | 1 | Device is in flash or passthrough mode |
| upload_valid | input | 1 | One-cycle strobe: a parsed command is uploaded |
| upload_opcode | input | 8 | Opcode of the uploaded command |
| upload_sets_busy | input | 1 | The uploaded command is configured to set busy |
| flash_busy | input | 1 | Current flash busy flag |
| flash_wel | input | 1 | Current write-enable latch |
| addr_4byte | input | 1 | Wide (4-byte) addressing currently enabled |
| addr_push | input | 1 | Push `addr_wdata` into the address queue |
| addr_wdata | input | 32 | Captured address word |
| cmd_pop | input | 1 | Pop one command record |
| addr_pop | input | 1 | Pop one address word |
| csb_release | input | 1 | One-cycle strobe: chip select released |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt state |
| cmd_rd_data | output | 32 | Head command record, 0 when empty |
| addr_rd_data | output | 32 | Head address word, 0 when empty |
| upload_status | output | 32 | Packed depth and not-empty flags |
| irq_cmd_ne | output | 1 | Command-queue-not-empty interrupt state |
| cmd_overflow | output | 1 | Dropped-upload error pulse |
| cmd_underflow | output | 1 | Empty-pop error pulse on the command queue |
| addr_overflow | output | 1 | Dropped address push error pulse |

## Verification
Some properties are checked on every cycle. These are the queue depth bounds, the held depth when a push is dropped, the emptiness that follows reset, the zero upper bits of every visible record, and the fact that the interrupt can only rise on a release or hold through a clear. The bench scenarios must show the rest. That covers the exact packing of each flag combination, first-in first-out ordering over a full queue, survival of the old records after an overflow, and the sequences of uploads and releases that do or do not raise the interrupt.

// File: rtl/flash_cmd_capture_pkg.sv
// Package: shared widths and the record packing for the command capture block.
// Assumes 32-bit queue words. Field positions are fixed by the consumer's decode.
package flash_cmd_capture_pkg;

    localparam int WORD_W   = 32;
    localparam int OPCODE_W = 8;
    localparam int BIT_BUSY = 8;
    localparam int BIT_WEL  = 9;
    localparam int BIT_A4B  = 10;

    typedef struct packed {
        logic [WORD_W-BIT_A4B-2:0] zero;
        logic                      a4b;
        logic                      wel;
        logic                      busy;
        logic [OPCODE_W-1:0]       opcode;
    } cmd_rec_t;

    // Build one command record from the opcode and the flags sampled at upload
    function automatic logic [WORD_W-1:0] pack_rec(input logic [OPCODE_W-1:0] op,
                                                   input logic busy,
                                                   input logic wel,
                                                   input logic a4b);
        cmd_rec_t r;
        r.zero   = '0;
        r.a4b    = a4b;
        r.wel    = wel;
        r.busy   = busy;
        r.opcode = op;
        return r;
    endfunction

endpackage

// File: rtl/capture_fifo.sv
// Module: capture_fifo
// A synchronous queue of WIDTH-bit words. It drops a push when full and returns
// zero on a pop when empty. Each case gives a one-cycle error pulse afterwards.
// Assumes: the full test uses the count before the edge, so a push and a pop
// in the same cycle on a full queue still drop the push.
module capture_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             ovf,
    output logic             unf
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    // Advance a pointer and wrap it at the last slot
    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write: data only, so no reset is needed
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointers, occupancy and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
            ovf   <= push && full;
            unf   <= pop && empty;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH) && ovf)); // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == '0) |=> (count == '0 && unf)); // R5
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !ovf && !unf)); // R10

endmodule

// File: rtl/upload_irq.sv
// Module: upload_irq
// Holds the pending-upload flag and the sticky command-not-empty interrupt state.
// Assumes: release and upload are one-cycle strobes. The release test uses the
// queue state before the edge. An upload in a release cycle counts for the next release.
module upload_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic flash_mode,
    input  logic upload,
    input  logic csb_release,
    input  logic cmd_not_empty,
    input  logic irq_clr,
    output logic irq
);

    logic pending;
    logic fire;

    assign fire = csb_release && flash_mode && cmd_not_empty && pending;

    // Pending flag: raised by any upload, consumed by any release
    always_ff @(posedge clk) begin
        if (!rst_n)           pending <= 1'b0;
        else if (upload)      pending <= 1'b1;
        else if (csb_release) pending <= 1'b0;
    end

    // Interrupt state: set on a qualifying release, write-one-to-clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (fire)    irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    AST_IRQ_RISE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(csb_release && flash_mode)); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R9

endmodule

// File: rtl/flash_cmd_capture.sv
// Module: flash_cmd_capture (top)
// Builds a command record with frozen flash flags on each upload and queues it.
// Also runs the address queue, packs the status word and drives the
// not-empty interrupt that is raised at chip-select release.
// Assumes: upload and address strobes come from an upstream decoder.
module flash_cmd_capture
    import flash_cmd_capture_pkg::*;
#(
    parameter int CMD_DEPTH  = 16,
    parameter int ADDR_DEPTH = 16,
    localparam int CCW       = $clog2(CMD_DEPTH + 1),
    localparam int ACW       = $clog2(ADDR_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_mode,
    input  logic              upload_valid,
    input  logic [7:0]        upload_opcode,
    input  logic              upload_sets_busy,
    input  logic              flash_busy,
    input  logic              flash_wel,
    input  logic              addr_4byte,
    input  logic              addr_push,
    input  logic [31:0]       addr_wdata,
    input  logic              cmd_pop,
    input  logic              addr_pop,
    input  logic              csb_release,
    input  logic              irq_clr,
    output logic [31:0]       cmd_rd_data,
    output logic [31:0]       addr_rd_data,
    output logic [31:0]       upload_status,
    output logic              irq_cmd_ne,
    output logic              cmd_overflow,
    output logic              cmd_underflow,
    output logic              addr_overflow
);

    logic [WORD_W-1:0] rec;
    logic [CCW-1:0]    cmd_cnt;
    logic [ACW-1:0]    addr_cnt;
    logic              addr_unf_unused;

    // Record build: busy already includes the command's own set-busy effect
    always_comb begin
        rec = pack_rec(upload_opcode, flash_busy | upload_sets_busy, flash_wel, addr_4byte);
    end

    capture_fifo #(.WIDTH(WORD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (upload_valid),
        .wdata (rec),
        .pop   (cmd_pop),
        .rdata (cmd_rd_data),
        .count (cmd_cnt),
        .ovf   (cmd_overflow),
        .unf   (cmd_underflow)
    );

    capture_fifo #(.WIDTH(WORD_W), .DEPTH(ADDR_DEPTH)) u_addr_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (addr_push),
        .wdata (addr_wdata),
        .pop   (addr_pop),
        .rdata (addr_rd_data),
        .count (addr_cnt),
        .ovf   (addr_overflow),
        .unf   (addr_unf_unused)
    );

    upload_irq u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .flash_mode    (flash_mode),
        .upload        (upload_valid),
        .csb_release   (csb_release),
        .cmd_not_empty (cmd_cnt != '0),
        .irq_clr       (irq_clr),
        .irq           (irq_cmd_ne)
    );

    // Status word packing: depths in the low bits of each byte pair, flags on top
    always_comb begin
        upload_status        = '0;
        upload_status[4:0]   = 5'(cmd_cnt);
        upload_status[7]     = (cmd_cnt != '0);
        upload_status[12:8]  = 5'(addr_cnt);
        upload_status[15]    = (addr_cnt != '0);
    end

    AST_REC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd_data[31:11] == '0); // R1
    AST_STATUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        upload_status[7] == (upload_status[4:0] != 5'd0)); // R6

endmodule

// File: tb/flash_cmd_capture_tb.sv
module flash_cmd_capture_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flash_mode = 1'b1;
    logic        upload_valid = 1'b0;
    logic [7:0]  upload_opcode = '0;
    logic        upload_sets_busy = 1'b0, flash_busy = 1'b0, flash_wel = 1'b0, addr_4byte = 1'b0;
    logic        addr_push = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic        cmd_pop = 1'b0, addr_pop = 1'b0, csb_release = 1'b0, irq_clr = 1'b0;
    logic [31:0] cmd_rd_data, addr_rd_data, upload_status;
    logic        irq_cmd_ne, cmd_overflow, cmd_underflow, addr_overflow;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_capture u_dut (.*);

    // {opcode, sets_busy, busy, wel, a4b, expected record}
    localparam logic [43:0] VEC [0:5] = '{
        {8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0003},
        {8'h02, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0302},
        {8'hB7, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_05B7},
        {8'h20, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0620},
        {8'hD8, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_07D8},
        {8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_04FF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stat(input int cd, input int ad);
        logic [31:0] s = '0;
        s[4:0] = 5'(cd); s[7] = (cd != 0); s[12:8] = 5'(ad); s[15] = (ad != 0);
        return s;
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic upload(input logic [7:0] op, input logic sb, b, w, a);
        upload_opcode = op; upload_sets_busy = sb; flash_busy = b; flash_wel = w; addr_4byte = a;
        upload_valid = 1'b1;
        cyc();
        upload_valid = 1'b0; upload_sets_busy = 1'b0; flash_busy = 1'b0; flash_wel = 1'b0; addr_4byte = 1'b0;
    endtask

    task automatic pop_cmd(input string req, input logic [31:0] exp);
        cmd_pop = 1'b1;
        #1 chk(req, cmd_rd_data, exp);
        cyc();
        cmd_pop = 1'b0;
    endtask

    task automatic release_cs();
        csb_release = 1'b1;
        cyc();
        csb_release = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10: outputs after reset
        chk("R10 status", upload_status, 32'h0);
        chk("R10 irq", {31'h0, irq_cmd_ne}, 32'h0);
        chk("R10 cmd data", cmd_rd_data, 32'h0);

        // Vector table: packing R1/R2, order R3, status R6
        foreach (VEC[i]) upload(VEC[i][43:36], VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32]);
        chk("R6 depth after table", upload_status, stat(6, 0));
        foreach (VEC[i]) pop_cmd("R1 R2 R3 record", VEC[i][31:0]);
        chk("R6 empty again", upload_status, stat(0, 0));

        // R5: pop while empty
        pop_cmd("R5 empty data", 32'h0);
        chk("R5 underflow pulse", {31'h0, cmd_underflow}, 32'h1);
        chk("R5 depth", upload_status, stat(0, 0));
        cyc();
        chk("R5 pulse single", {31'h0, cmd_underflow}, 32'h0);

        // R4: fill and overflow
        for (int k = 0; k < 16; k++) upload(8'(8'h40 + k), 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 full depth", upload_status, stat(16, 0));
        chk("R4 no pulse yet", {31'h0, cmd_overflow}, 32'h0);
        // R7: release on full queue raises the interrupt
        release_cs();
        chk("R7 irq set", {31'h0, irq_cmd_ne}, 32'h1);
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        chk("R9 cleared", {31'h0, irq_cmd_ne}, 32'h0);
        // R8: release with no new upload does nothing
        release_cs();
        chk("R8 no repeat irq", {31'h0, irq_cmd_ne}, 32'h0);
        upload(8'h99, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R4 overflow pulse", {31'h0, cmd_overflow}, 32'h1);
        chk("R4 depth held", upload_status, stat(16, 0));
        cyc();
        chk("R4 pulse single", {31'h0, cmd_overflow}, 32'h0);
        // R8: the dropped upload still arms the interrupt
        release_cs();
        chk("R8 dropped upload arms irq", {31'h0, irq_cmd_ne}, 32'h1);
        // R9: set and clear together: set wins
        upload(8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
        csb_release = 1'b1; irq_clr = 1'b1; cyc(); csb_release = 1'b0; irq_clr = 1'b0;
        chk("R9 set wins", {31'h0, irq_cmd_ne}, 32'h1);
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        for (int k = 0; k < 16; k++) pop_cmd("R4 old records kept", 32'(8'h40 + k));

        // R7: release while empty, and with flash mode off
        upload(8'h05, 1'b0, 1'b0, 1'b0, 1'b0);
        pop_cmd("R3 single", 32'h5);
        release_cs();
        chk("R7 empty no irq", {31'h0, irq_cmd_ne}, 32'h0);
        upload(8'h06, 1'b0, 1'b0, 1'b0, 1'b0);
        flash_mode = 1'b0;
        release_cs();
        chk("R7 mode off no irq", {31'h0, irq_cmd_ne}, 32'h0);
        flash_mode = 1'b1;

        // R11: address queue
        for (int k = 0; k < 16; k++) begin
            addr_push = 1'b1; addr_wdata = 32'h1000_0000 + 32'(k); cyc();
        end
        addr_wdata = 32'hDEAD_BEEF; cyc(); addr_push = 1'b0;
        chk("R11 addr overflow", {31'h0, addr_overflow}, 32'h1);
        chk("R6 R11 status", upload_status, stat(1, 16));
        addr_pop = 1'b1;
        #1 chk("R11 addr head", addr_rd_data, 32'h1000_0000);
        cyc(); addr_pop = 1'b0;
        chk("R6 addr depth", upload_status, stat(1, 15));

        // R10: reset empties both queues and the interrupt
        upload(8'h07, 1'b0, 1'b0, 1'b0, 1'b0);
        release_cs();
        chk("R7 before reset", {31'h0, irq_cmd_ne}, 32'h1);
        do_reset();
        chk("R10 status empty", upload_status, 32'h0);
        chk("R10 irq cleared", {31'h0, irq_cmd_ne}, 32'h0);
        chk("R10 addr data", addr_rd_data, 32'h0);
        // R10: pending flag cleared, so a bare release raises nothing
        release_cs();
        chk("R10 pending cleared", {31'h0, irq_cmd_ne}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule